// File: doc/BRIEF.md
# Conversion Result Latch with Coherent Byte Readout

This block stores the 10-bit word produced by an analog-to-digital converter and lets an 8-bit bus master read it as two bytes: an upper byte and a lower byte. Each result arrives on a valid-qualified input. The input has no ready signal and applies no back-pressure. A result that cannot be stored is dropped, and the block records that the drop happened.

Readout goes through a byte-wide port. A read enable and a 2-bit register select choose the byte. The read data is combinational and reflects the state before the clock edge that ends the read. Reading the lower byte holds the stored word until the upper byte is read. Software that reads the lower byte first and the upper byte second therefore always gets two halves of the same conversion. An alignment input chooses right or left justification when the word is placed into the two bytes. With left justification, a reader that needs only 8 bits can read the upper byte alone.

A third select value returns a status byte. Its bit 0 is a sticky flag that reports dropped results. Its bit 1 shows whether the hold is currently set.

Top module: `adc_result_latch`

## Requirements
- R1: When `res_valid` is high, no hold is set and no lower-byte read occurs in that cycle, `res_data` is stored and becomes readable from the next cycle.
- R2: With `left_align` low, the upper byte (select 1) has stored bits 9:8 in bits 1:0 and zeros in bits 7:2. The lower byte (select 0) returns stored bits 7:0.
- R3: With `left_align` high, the upper byte returns stored bits 9:2. The lower byte has stored bits 1:0 in bits 7:6 and zeros in bits 5:0.
- R4: Changing `left_align` only changes how the bytes are formatted on readout. The stored word stays the same, so switching back returns the earlier bytes.
- R5: A lower-byte read sets the hold. While the hold is set, a valid result is not stored and the previous word stays readable.
- R6: An upper-byte read clears the hold. An upper-byte read while no hold is set leaves the hold clear and only returns data.
- R7: A valid result that arrives in the same cycle as an upper-byte read is stored, even when the hold was set.
- R8: A valid result that arrives in the same cycle as a lower-byte read is dropped, and the hold is set.
- R9: Each dropped result sets the lost flag (status select 2, bit 0). Status bit 1 shows the hold, and status bits 7:2 read zero. A status read clears the lost flag, unless a drop happens in that same cycle.
- R10: A synchronous active-high `rst` clears the stored word, the hold and the lost flag, so all three selects read zero afterwards.
- R11: `rd_data` is zero when `rd_en` is low or when the select is 3.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| res_valid | input | 1 | New conversion result present this cycle |
| res_data | input | 10 | Conversion result word |
| left_align | input | 1 | 1 = left-justified bytes, 0 = right-justified |
| rd_en | input | 1 | Bus read strobe |
| rd_addr | input | 2 | 0 lower byte, 1 upper byte, 2 status, 3 unused |
| rd_data | output | 8 | Combinational read data |

## Verification
The assertions assume `res_valid` and `rd_en` are known in every cycle. They also assume a read is one cycle long and changes state only at the edge that ends it. The stimulus follows these rules: inputs change only at the falling edge, every read is a single-cycle pulse, and randomly chosen selects cover all four values. It also drives results into the same cycle as lower-byte and upper-byte reads, so the same-cycle ordering rules are exercised.

// File: rtl/adc_result_pkg.sv
package adc_result_pkg;
  typedef enum logic [1:0] {
    SEL_LOW  = 2'd0,
    SEL_HIGH = 2'd1,
    SEL_STAT = 2'd2,
    SEL_NONE = 2'd3
  } byte_sel_e;
endpackage

// File: rtl/result_hold.sv
module result_hold #(
  parameter int DATA_W = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_data,
  input  logic              rd_low,
  input  logic              rd_high,
  input  logic              rd_stat,
  output logic [DATA_W-1:0] word_q,
  output logic              held_q,
  output logic              lost_q
);
  logic accept;
  logic drop;

  // A lower-byte read takes effect before a result in the same cycle.
  // An upper-byte read releases the hold before a result in the same cycle.
  assign accept = in_valid && !rd_low && (!held_q || rd_high);
  assign drop   = in_valid && !accept;

  always_ff @(posedge clk) begin
    if (rst) begin
      word_q <= '0;
      held_q <= 1'b0;
      lost_q <= 1'b0;
    end else begin
      if (accept) word_q <= in_data;
      if (rd_low)       held_q <= 1'b1;
      else if (rd_high) held_q <= 1'b0;
      if (drop)         lost_q <= 1'b1;
      else if (rd_stat) lost_q <= 1'b0;
    end
  end

  // R5
  held_keep_chk: assert property (@(posedge clk) disable iff (rst)
    (held_q && in_valid && !rd_high) |=> $stable(word_q));
  // R5
  low_sets_hold_chk: assert property (@(posedge clk) disable iff (rst)
    rd_low |=> held_q);
  // R6
  high_clears_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_high && !rd_low) |=> !held_q);
  // R1
  free_load_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !held_q && !rd_low) |=> (word_q == $past(in_data)));
  // R7
  release_load_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && rd_high && !rd_low) |=> (word_q == $past(in_data)));
  // R9
  lost_set_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !rd_high && (held_q || rd_low)) |=> lost_q);
endmodule

// File: rtl/result_align.sv
module result_align #(
  parameter int DATA_W = 10,
  parameter int BYTE_W = 8
) (
  input  logic [DATA_W-1:0] word,
  input  logic              left,
  output logic [BYTE_W-1:0] high_byte,
  output logic [BYTE_W-1:0] low_byte
);
  localparam int PAIR_W = 2 * BYTE_W;
  localparam int PAD_W  = PAIR_W - DATA_W;

  logic [PAIR_W-1:0] pair_right;
  logic [PAIR_W-1:0] pair_left;
  logic [PAIR_W-1:0] pair;

  assign pair_right = {{PAD_W{1'b0}}, word};
  assign pair_left  = {word, {PAD_W{1'b0}}};
  assign pair       = left ? pair_left : pair_right;
  assign high_byte  = pair[PAIR_W-1:BYTE_W];
  assign low_byte   = pair[BYTE_W-1:0];
endmodule

// File: rtl/read_select.sv
module read_select
  import adc_result_pkg::*;
#(
  parameter int BYTE_W = 8
) (
  input  logic              rd_en,
  input  logic [1:0]        rd_addr,
  input  logic [BYTE_W-1:0] high_byte,
  input  logic [BYTE_W-1:0] low_byte,
  input  logic              held,
  input  logic              lost,
  output logic [BYTE_W-1:0] rd_data,
  output logic              rd_low,
  output logic              rd_high,
  output logic              rd_stat
);
  byte_sel_e sel;
  assign sel     = byte_sel_e'(rd_addr);
  assign rd_low  = rd_en && (sel == SEL_LOW);
  assign rd_high = rd_en && (sel == SEL_HIGH);
  assign rd_stat = rd_en && (sel == SEL_STAT);

  always_comb begin
    rd_data = '0;
    if (rd_en) begin
      unique case (sel)
        SEL_LOW:  rd_data = low_byte;
        SEL_HIGH: rd_data = high_byte;
        SEL_STAT: rd_data = {{(BYTE_W-2){1'b0}}, held, lost};
        SEL_NONE: rd_data = '0;
      endcase
    end
  end
endmodule

// File: rtl/adc_result_latch.sv
module adc_result_latch #(
  parameter int DATA_W = 10,
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              res_valid,
  input  logic [DATA_W-1:0] res_data,
  input  logic              left_align,
  input  logic              rd_en,
  input  logic [1:0]        rd_addr,
  output logic [BYTE_W-1:0] rd_data
);
  localparam int HIGH_USED = DATA_W - BYTE_W;

  logic [DATA_W-1:0] word_q;
  logic              held_q;
  logic              lost_q;
  logic [BYTE_W-1:0] high_byte;
  logic [BYTE_W-1:0] low_byte;
  logic              rd_low;
  logic              rd_high;
  logic              rd_stat;

  result_hold #(.DATA_W(DATA_W)) hold_i (
    .clk(clk), .rst(rst), .in_valid(res_valid), .in_data(res_data),
    .rd_low(rd_low), .rd_high(rd_high), .rd_stat(rd_stat),
    .word_q(word_q), .held_q(held_q), .lost_q(lost_q)
  );

  result_align #(.DATA_W(DATA_W), .BYTE_W(BYTE_W)) align_i (
    .word(word_q), .left(left_align),
    .high_byte(high_byte), .low_byte(low_byte)
  );

  read_select #(.BYTE_W(BYTE_W)) sel_i (
    .rd_en(rd_en), .rd_addr(rd_addr),
    .high_byte(high_byte), .low_byte(low_byte),
    .held(held_q), .lost(lost_q),
    .rd_data(rd_data), .rd_low(rd_low), .rd_high(rd_high), .rd_stat(rd_stat)
  );

  // R2
  right_pad_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_en && rd_addr == 2'd1 && !left_align) |-> (rd_data[BYTE_W-1:HIGH_USED] == '0));
  // R11
  idle_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (!rd_en || rd_addr == 2'd3) |-> (rd_data == '0));
  // R9
  stat_pad_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_en && rd_addr == 2'd2) |-> (rd_data[BYTE_W-1:2] == '0));
endmodule

// File: tb/adc_result_latch_tb.sv
module adc_result_latch_tb_top;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst;
  logic       res_valid;
  logic [9:0] res_data;
  logic       left_align;
  logic       rd_en;
  logic [1:0] rd_addr;
  logic [7:0] rd_data;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [9:0] m_word;
  logic       m_held;
  logic       m_lost;

  always #(CLK_PERIOD/2) clk = ~clk;

  adc_result_latch dut_i (
    .clk(clk), .rst(rst), .res_valid(res_valid), .res_data(res_data),
    .left_align(left_align), .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data)
  );

  function automatic logic [7:0] exp_read(input logic re, input logic [1:0] a, input logic la);
    if (!re) return 8'h00;
    case (a)
      2'd0: return la ? {m_word[1:0], 6'b0} : m_word[7:0];
      2'd1: return la ? m_word[9:2] : {6'b0, m_word[9:8]};
      2'd2: return {6'b0, m_held, m_lost};
      default: return 8'h00;
    endcase
  endfunction

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: rd_data=%h expected=%h", tag, act, exp);
    end
  endtask

  // One cycle: drive at the falling edge, check combinational read data, update the model at the edge.
  task automatic cyc(input logic v, input logic [9:0] d, input logic re,
                     input logic [1:0] a, input logic la, input string tag);
    logic lo, hi, st, acc;
    res_valid = v; res_data = d; rd_en = re; rd_addr = a; left_align = la;
    #1;
    check(tag, rd_data, exp_read(re, a, la));
    lo  = re && a == 2'd0;
    hi  = re && a == 2'd1;
    st  = re && a == 2'd2;
    acc = v && !lo && (!m_held || hi);
    @(posedge clk);
    if (acc) m_word = d;
    if (lo) m_held = 1'b1; else if (hi) m_held = 1'b0;
    if (v && !acc) m_lost = 1'b1; else if (st) m_lost = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: rd_data=%h expected=end of run", rd_data);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    rst = 1'b1; res_valid = 0; res_data = 0; rd_en = 0; rd_addr = 0; left_align = 0;
    m_word = 0; m_held = 0; m_lost = 0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R10: all selects read zero after reset
    cyc(0, 0, 1, 2'd2, 0, "R10");
    cyc(0, 0, 1, 2'd1, 0, "R10");
    cyc(0, 0, 1, 2'd0, 0, "R10");
    cyc(0, 0, 1, 2'd1, 0, "R10");
    // R1 load, R2 right format, R6 high read without hold
    cyc(1, 10'h2D5, 0, 2'd0, 0, "R1");
    cyc(0, 0, 1, 2'd1, 0, "R6");
    cyc(0, 0, 1, 2'd2, 0, "R6");
    cyc(0, 0, 1, 2'd0, 0, "R2");
    cyc(0, 0, 1, 2'd1, 0, "R2");
    // R3 left format, R4 reformat only
    cyc(0, 0, 1, 2'd1, 1, "R3");
    cyc(0, 0, 1, 2'd0, 1, "R3");
    cyc(0, 0, 1, 2'd1, 0, "R4");
    cyc(0, 0, 1, 2'd1, 1, "R4");
    // R5 hold drops result, R9 lost flag
    cyc(0, 0, 1, 2'd0, 0, "R5");
    cyc(1, 10'h155, 0, 2'd0, 0, "R5");
    cyc(0, 0, 1, 2'd2, 0, "R9");
    cyc(0, 0, 1, 2'd2, 0, "R9");
    cyc(0, 0, 1, 2'd1, 0, "R5");
    // R7 release and load in one cycle
    cyc(0, 0, 1, 2'd0, 0, "R7");
    cyc(1, 10'h3AA, 1, 2'd1, 0, "R7");
    cyc(0, 0, 1, 2'd0, 0, "R7");
    cyc(0, 0, 1, 2'd1, 0, "R7");
    // R8 result with lower read is dropped
    cyc(1, 10'h111, 1, 2'd0, 0, "R8");
    cyc(0, 0, 1, 2'd1, 0, "R8");
    cyc(0, 0, 1, 2'd2, 0, "R8");
    // R9 drop during status read keeps flag set
    cyc(0, 0, 1, 2'd0, 0, "R9");
    cyc(1, 10'h0F0, 1, 2'd2, 0, "R9");
    cyc(0, 0, 1, 2'd2, 0, "R9");
    cyc(0, 0, 1, 2'd1, 0, "R9");
    // R11 idle and unused select
    cyc(0, 0, 1, 2'd3, 0, "R11");
    cyc(0, 0, 0, 2'd1, 1, "R11");
    // Random mix
    for (int i = 0; i < 4000; i++) begin
      logic v, re, la;
      logic [1:0] a;
      v  = ($urandom % 3) == 0;
      re = ($urandom % 2) == 0;
      a  = 2'($urandom % 4);
      la = ($urandom % 8) == 0 ? ~left_align : left_align;
      cyc(v, 10'($urandom), re, a, la,
          (a == 2'd2) ? "R9" : (a == 2'd3 || !re) ? "R11" : la ? "R3" : "R2");
    end
    // R10 reset mid-run clears state
    rst = 1'b1; @(negedge clk); rst = 1'b0;
    m_word = 0; m_held = 0; m_lost = 0;
    cyc(0, 0, 1, 2'd2, 0, "R10");
    cyc(0, 0, 1, 2'd1, 1, "R10");
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule